// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits between an instruction sequencer and a single program-memory bus that carries both instruction fetches and data transfers. When the sequencer fetches an instruction in the same cycle as a data access on that bus, the data access wins. The fetch is then repeated in the following cycle. That repeated fetch is the only event that writes a line into the cache. On later passes through the same code, usually a tight loop, the cached copy is delivered in the same cycle as the data access, so the loop runs without stalls.

Fetches that miss without a data access pending go straight to memory and leave the cache unchanged. A fetch that hits is always served from the cache and does not use the bus. The storage is direct-mapped. A flush input invalidates every line at once.

Top module: `conflict_icache`

## Requirements
- R1: After reset every line is invalid, `fetch_rdy` is 0 while `fetch_req` is 0, and `imem_req` is 0.
- R2: A fetch whose address hits delivers the stored 48-bit word with `fetch_rdy`=1 in the same cycle and does not raise `imem_req`, whatever the level of `dacc_pend`.
- R3: A fetch that misses while `dacc_pend`=1 is a conflict. In that cycle `fetch_rdy`=0 and `imem_req`=0, and the fetch address is captured.
- R4: In each cycle after a conflict, the cache raises `imem_req` with the captured address. In the cycle `imem_gnt`=1 it forwards `imem_rdata` with `fetch_rdy`=1 and writes the word into its line, so a later fetch of that address hits.
- R5: While a refill waits with `imem_gnt`=0, `fetch_rdy` stays 0 and `imem_req` and `imem_addr` hold their values.
- R6: A miss with `dacc_pend`=0 drives `imem_req`=1 with `imem_addr`=`fetch_addr`, and `fetch_rdy` follows `imem_gnt` in the same cycle with `fetch_instr`=`imem_rdata`. It does not allocate, so a later conflicting fetch of that address still stalls.
- R7: The line index is `fetch_addr[4:0]` and the remaining upper bits form the tag. A refill to an address with the same index and a different tag replaces the older line.
- R8: `flush`=1 at a clock edge clears all valid bits. If a refill completes in that same cycle, the word is still delivered but the line is not kept.
- R9: Instruction words are 48 bits wide end to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| fetch_req | input | 1 | Sequencer fetch request, held until `fetch_rdy` |
| fetch_addr | input | 16 | Fetch address |
| fetch_rdy | output | 1 | Instruction delivered this cycle |
| fetch_instr | output | 48 | Delivered instruction |
| dacc_pend | input | 1 | Data access on the program-memory bus this cycle |
| imem_req | output | 1 | Instruction request on the program-memory bus |
| imem_addr | output | 16 | Instruction address on the bus |
| imem_gnt | input | 1 | Bus grant, with data valid in the same cycle |
| imem_rdata | input | 48 | Instruction word read from the bus |

## Verification
The assertions check the rules of each single cycle on every clock:
- a hit never uses the bus;
- a conflict miss stalls with the bus idle, then requests the captured address;
- a refill that is not granted holds its request;
- a flush leaves no valid line;
- a completed write is visible to a lookup of the same address.

Some behaviours can only be shown by a sequence of stimulus, and the bench's scenarios cover these:
- a non-conflicting miss left nothing behind;
- a same-index refill evicted the older tag;
- a hit returns the word captured at fill time rather than the current memory contents.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } ic_state_e;
endpackage

// File: rtl/icache_lines.sv
module icache_lines #(
    parameter int AW      = 16,
    parameter int IW      = 48,
    parameter int ENTRIES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] rd_addr,
    output logic          hit,
    output logic [IW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] wr_data
);
    localparam int IDXW = $clog2(ENTRIES);
    localparam int TAGW = AW - IDXW;

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAGW-1:0]    tag_mem [ENTRIES];
    logic [IW-1:0]      word_mem [ENTRIES];

    logic [IDXW-1:0] rd_idx, wr_idx;
    logic [TAGW-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_addr[IDXW-1:0];
    assign rd_tag = rd_addr[AW-1:IDXW];
    assign wr_idx = wr_addr[IDXW-1:0];
    assign wr_tag = wr_addr[AW-1:IDXW];

    assign hit     = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_data = word_mem[rd_idx];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
        if (flush) valid_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            word_mem[wr_idx] <= wr_data;
        end
    end

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R4
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> ((rd_addr != $past(wr_addr)) || (hit && rd_data == $past(wr_data))));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_rdy,
    output logic [IW-1:0] fetch_instr,
    input  logic          dacc_pend,
    input  logic          hit,
    input  logic [IW-1:0] line_data,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_gnt,
    input  logic [IW-1:0] imem_rdata,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [IW-1:0] wr_data
);
    typedef struct packed {
        ic_state_e     st;
        logic [AW-1:0] addr;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        fetch_rdy   = 1'b0;
        fetch_instr = line_data;
        imem_req    = 1'b0;
        imem_addr   = fetch_addr;
        wr_en       = 1'b0;
        wr_addr     = r_q.addr;
        wr_data     = imem_rdata;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fetch_req) begin
                    if (hit) begin
                        fetch_rdy = 1'b1;
                    end else if (dacc_pend) begin
                        r_d.st   = ST_REFILL;
                        r_d.addr = fetch_addr;
                    end else begin
                        imem_req    = 1'b1;
                        fetch_rdy   = imem_gnt;
                        fetch_instr = imem_rdata;
                    end
                end
            end
            ST_REFILL: begin
                imem_req    = 1'b1;
                imem_addr   = r_q.addr;
                fetch_instr = imem_rdata;
                if (imem_gnt) begin
                    fetch_rdy = 1'b1;
                    wr_en     = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, addr: '0};
        else        r_q <= r_d;
    end

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && fetch_req && hit) |-> (fetch_rdy && !imem_req));

    // R3
    conflict_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && fetch_req && !hit && dacc_pend) |-> (!fetch_rdy && !imem_req));

    // R4
    refill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && fetch_req && !hit && dacc_pend) |=> (imem_req && imem_addr == $past(fetch_addr)));

    // R5
    refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REFILL && !imem_gnt) |=> (imem_req && !$past(fetch_rdy) && $stable(imem_addr)));

    // R6
    plain_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && fetch_req && !hit && !dacc_pend) |-> (imem_req && imem_addr == fetch_addr && !wr_en));
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
    parameter int AW      = 16,
    parameter int IW      = 48,
    parameter int ENTRIES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_rdy,
    output logic [IW-1:0] fetch_instr,
    input  logic          dacc_pend,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_gnt,
    input  logic [IW-1:0] imem_rdata
);
    logic          hit;
    logic [IW-1:0] line_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [IW-1:0] wr_data;

    icache_lines #(.AW(AW), .IW(IW), .ENTRIES(ENTRIES)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_addr (fetch_addr),
        .hit     (hit),
        .rd_data (line_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    icache_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_rdy   (fetch_rdy),
        .fetch_instr (fetch_instr),
        .dacc_pend   (dacc_pend),
        .hit         (hit),
        .line_data   (line_data),
        .imem_req    (imem_req),
        .imem_addr   (imem_addr),
        .imem_gnt    (imem_gnt),
        .imem_rdata  (imem_rdata),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req && !$past(fetch_req) && !$past(dacc_pend) |-> !fetch_rdy);
endmodule

// File: tb/sim_conflict_icache.sv
module sim_conflict_icache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [47:0] fetch_instr;
    logic        dacc_pend = 1'b0;
    logic        imem_req;
    logic [15:0] imem_addr;
    logic        imem_gnt;
    logic [47:0] imem_rdata;
    logic [15:0] salt = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [47:0] word_of(logic [15:0] a, logic [15:0] s);
        return {a ^ s, ~a, a};
    endfunction

    // Bus model: data access has priority, one-cycle access
    assign imem_gnt   = imem_req && !dacc_pend;
    assign imem_rdata = word_of(imem_addr, salt);

    conflict_icache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_instr(fetch_instr),
        .dacc_pend(dacc_pend),
        .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_gnt(imem_gnt), .imem_rdata(imem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {addr[16], dpend, salt[16], exp_rdy, exp_req, exp_salt[16]}
    localparam int NV = 13;
    localparam logic [50:0] VEC [NV] = '{
        {16'h0010, 1'b0, 16'h0001, 1'b1, 1'b1, 16'h0001},
        {16'h0010, 1'b1, 16'h0002, 1'b0, 1'b0, 16'h0000},
        {16'h0010, 1'b0, 16'h0002, 1'b1, 1'b1, 16'h0002},
        {16'h0010, 1'b1, 16'h0003, 1'b1, 1'b0, 16'h0002},
        {16'h0010, 1'b0, 16'h0003, 1'b1, 1'b0, 16'h0002},
        {16'h0030, 1'b1, 16'h0003, 1'b0, 1'b0, 16'h0000},
        {16'h0030, 1'b1, 16'h0003, 1'b0, 1'b1, 16'h0000},
        {16'h0030, 1'b0, 16'h0004, 1'b1, 1'b1, 16'h0004},
        {16'h0010, 1'b0, 16'h0005, 1'b1, 1'b1, 16'h0005},
        {16'h0030, 1'b1, 16'h0005, 1'b1, 1'b0, 16'h0004},
        {16'h0011, 1'b1, 16'h0005, 1'b0, 1'b0, 16'h0000},
        {16'h0011, 1'b0, 16'h0006, 1'b1, 1'b1, 16'h0006},
        {16'h0011, 1'b1, 16'h0007, 1'b1, 1'b0, 16'h0006}
    };

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 48'h0, 48'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!fetch_rdy, "R1 rdy", {47'h0, fetch_rdy}, 48'h0);
        chk(!imem_req, "R1 req", {47'h0, imem_req}, 48'h0);

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fetch_req  = 1'b1;
            fetch_addr = VEC[i][50:35];
            dacc_pend  = VEC[i][34];
            salt       = VEC[i][33:18];
            #1;
            chk(fetch_rdy == VEC[i][17], "R2/R3/R5 rdy", {47'h0, fetch_rdy}, {47'h0, VEC[i][17]});
            chk(imem_req == VEC[i][16], "R3/R4/R6 req", {47'h0, imem_req}, {47'h0, VEC[i][16]});
            if (VEC[i][16])
                chk(imem_addr == fetch_addr, "R4/R6 addr", {32'h0, imem_addr}, {32'h0, fetch_addr});
            if (VEC[i][17])
                chk(fetch_instr == word_of(fetch_addr, VEC[i][15:0]), "R9/R7 instr",
                    fetch_instr, word_of(fetch_addr, VEC[i][15:0]));
        end

        // R8 flush clears a cached line
        @(negedge clk);
        fetch_req = 1'b0;
        dacc_pend = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        fetch_req = 1'b1;
        fetch_addr = 16'h0011;
        dacc_pend = 1'b1;
        #1;
        chk(!fetch_rdy, "R8 flushed miss", {47'h0, fetch_rdy}, 48'h0);
        // R8 flush coincides with refill completion
        @(negedge clk);
        dacc_pend = 1'b0;
        salt = 16'h0009;
        flush = 1'b1;
        #1;
        chk(fetch_rdy && fetch_instr == word_of(16'h0011, 16'h0009), "R8 refill delivered",
            fetch_instr, word_of(16'h0011, 16'h0009));
        @(negedge clk);
        flush = 1'b0;
        dacc_pend = 1'b1;
        #1;
        chk(!fetch_rdy && !imem_req, "R8 line not kept", {46'h0, fetch_rdy, imem_req}, 48'h0);
        @(negedge clk);
        fetch_req = 1'b0;
        dacc_pend = 1'b0;
        #1;
        @(negedge clk);
        #1;
        chk(!fetch_rdy, "R1 idle no rdy", {47'h0, fetch_rdy}, 48'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule